// File: doc/BRIEF.md
# Programmable Character Generator RAM Controller

This block lets a CPU load glyph images into an external character RAM that sits next to a legacy video display generator. A four-byte register window on the CPU bus holds a mode/control byte and a write-data byte. The block keeps its own 11-bit character-RAM address counter. Software advances the counter by pulsing one control bit from 0 to 1. A write to the data register copies the byte into the RAM at the current counter address. The copy happens only if writing is enabled and the display is using the internal character source.

The block also drives the video generator's invert and semigraphics inputs. Each signal comes either from a fixed register bit or, in automatic mode, from a bit of the video data byte being displayed. The character RAM is modelled as a synchronous array. Its read port, driven by the video side, returns the byte one clock after the address is presented.

The CPU bus is a plain register interface with no back-pressure. Every access completes in the cycle it is presented. Writes are taken on the clock edge while `cpu_wr` is high. Reads are combinational from `cpu_addr`. The glyph read port is likewise always ready, with a fixed latency of one cycle.

Top module: `chargen_ctrl`

## Requirements
- R1: The window is selected only when `cpu_addr[15:2]` equals that of BASE_ADDR (default 16'hFF44, so $FF44-$FF47). Writes to other addresses, such as $FF40-$FF43 or $FF48, change nothing. Reads outside the window return 8'h00.
- R2: Offset 0 is the control register and offset 2 is the data register. Both read back the last byte written, all 8 bits. Offsets 1 and 3 read 8'h00, and writes to them are ignored.
- R3: After reset the control and data registers read 8'h00 and the address counter is 0. As a result `ext_char`, `vid_inv` and `vid_sg` are all low.
- R4: `ext_char` equals control bit 0 (0 = internal character source, 1 = external).
- R5: When control bit 1 is set, `vid_inv` follows `vid_data[6]`. Otherwise it equals control bit 2. Automatic mode takes priority over the manual bit.
- R6: When control bit 3 is set, `vid_sg` follows `vid_data[7]`. Otherwise it equals control bit 4. Automatic mode takes priority over the manual bit.
- R7: A control write that takes bit 6 from 0 to 1 advances the address counter by one. The counter wraps from 2047 to 0. A control write that leaves bit 6 at 1, or clears it, does not advance the counter.
- R8: A data-register write while control bit 5 is 1 and bit 0 is 0 stores the byte at the counter address. Presenting that address on `glyph_addr` returns the byte on `glyph_data` one clock later.
- R9: A data-register write while control bit 0 is 1, or while bit 5 is 0, leaves the character RAM unchanged.
- R10: Control bit 7 is stored and read back but has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wr | input | 1 | Write strobe, taken on the rising clock edge |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr` (combinational) |
| vid_data | input | 8 | Video data byte currently being displayed |
| vid_inv | output | 1 | Invert signal to the video generator |
| vid_sg | output | 1 | Semigraphics signal to the video generator |
| ext_char | output | 1 | 1 selects the external character image source |
| glyph_addr | input | 11 | Character RAM read address from the video side |
| glyph_data | output | 8 | Character RAM read data, one cycle after `glyph_addr` |

## Verification
Random control bytes, biased toward the internal source, are mixed with random data writes and random video bytes. This pattern separates the gated write path from the suppressed one and separates automatic from manual selection of both video signals. Random control writes also alternate bit 6 in every combination, which distinguishes counting on a rising edge from counting on a level. Directed cases cover the window's neighbouring addresses and the unused offsets. They also cover a counter walk across the 2047-to-0 wrap and a known byte that must survive a suppressed write.

// File: rtl/chargen_pkg.sv
package chargen_pkg;
  localparam logic [1:0] OFF_CTRL = 2'd0;
  localparam logic [1:0] OFF_DATA = 2'd2;

  localparam int B_EXT     = 0;
  localparam int B_INV_AUTO = 1;
  localparam int B_INV_MAN = 2;
  localparam int B_SG_AUTO = 3;
  localparam int B_SG_MAN  = 4;
  localparam int B_WR_EN   = 5;
  localparam int B_ADV     = 6;

  localparam int VD_INV_BIT = 6;
  localparam int VD_SG_BIT  = 7;
endpackage

// File: rtl/chargen_regs.sv
module chargen_regs
  import chargen_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 8,
  parameter int          CNT_W     = 11,
  parameter logic [15:0] BASE_ADDR = 16'hFF44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    cpu_addr,
  input  logic             cpu_wr,
  input  logic [DW-1:0]    cpu_wdata,
  output logic [DW-1:0]    cpu_rdata,
  output logic [DW-1:0]    ctrl_q,
  output logic             ram_we,
  output logic [CNT_W-1:0] ram_waddr,
  output logic [DW-1:0]    ram_wdata
);
  logic             sel;
  logic [1:0]       off;
  logic             ctrl_we, data_we, adv_rise;
  logic [DW-1:0]    data_q;
  logic [CNT_W-1:0] cnt_q;

  assign sel      = (cpu_addr[AW-1:2] == BASE_ADDR[AW-1:2]);
  assign off      = cpu_addr[1:0];
  assign ctrl_we  = cpu_wr && sel && (off == OFF_CTRL);
  assign data_we  = cpu_wr && sel && (off == OFF_DATA);
  assign adv_rise = ctrl_we && cpu_wdata[B_ADV] && !ctrl_q[B_ADV];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (ctrl_we)  ctrl_q <= cpu_wdata;
      if (data_we)  data_q <= cpu_wdata;
      if (adv_rise) cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign ram_we    = data_we && ctrl_q[B_WR_EN] && !ctrl_q[B_EXT];
  assign ram_waddr = cnt_q;
  assign ram_wdata = cpu_wdata;

  always_comb begin
    cpu_rdata = '0;
    if (sel) begin
      case (off)
        OFF_CTRL: cpu_rdata = ctrl_q;
        OFF_DATA: cpu_rdata = data_q;
        default:  cpu_rdata = '0;
      endcase
    end
  end

  a_r7_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && sel && off == OFF_CTRL && cpu_wdata[B_ADV] && !ctrl_q[B_ADV])
      |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r7_counter_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && sel && off == OFF_CTRL) |=> $stable(cnt_q));

  a_r1_outside_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !sel) |=> ($stable(ctrl_q) && $stable(data_q) && $stable(cnt_q)));

  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && sel && off == OFF_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/chargen_mode_mux.sv
module chargen_mode_mux
  import chargen_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] ctrl_q,
  input  logic [DW-1:0] vid_data,
  output logic          vid_inv,
  output logic          vid_sg,
  output logic          ext_char
);
  assign vid_inv  = ctrl_q[B_INV_AUTO] ? vid_data[VD_INV_BIT] : ctrl_q[B_INV_MAN];
  assign vid_sg   = ctrl_q[B_SG_AUTO]  ? vid_data[VD_SG_BIT]  : ctrl_q[B_SG_MAN];
  assign ext_char = ctrl_q[B_EXT];

  always_comb begin
    // R10: the top control bit never reaches an output
    if (ctrl_q[B_INV_AUTO:0] == '0 && ctrl_q[B_SG_MAN:B_INV_MAN] == '0)
      a_r10_idle_low: assert (!vid_inv && !vid_sg && !ext_char);
  end
endmodule

// File: rtl/chargen_ram.sv
module chargen_ram #(
  parameter int DW = 8,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/chargen_ctrl.sv
module chargen_ctrl
  import chargen_pkg::*;
#(
  parameter int          CNT_W     = 11,
  parameter logic [15:0] BASE_ADDR = 16'hFF44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      cpu_addr,
  input  logic             cpu_wr,
  input  logic [7:0]       cpu_wdata,
  output logic [7:0]       cpu_rdata,
  input  logic [7:0]       vid_data,
  output logic             vid_inv,
  output logic             vid_sg,
  output logic             ext_char,
  input  logic [CNT_W-1:0] glyph_addr,
  output logic [7:0]       glyph_data
);
  localparam int DW = 8;

  logic [DW-1:0]    ctrl_q;
  logic             ram_we;
  logic [CNT_W-1:0] ram_waddr;
  logic [DW-1:0]    ram_wdata;

  chargen_regs #(.AW(16), .DW(DW), .CNT_W(CNT_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ctrl_q(ctrl_q),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  chargen_mode_mux #(.DW(DW)) u_mux (
    .ctrl_q(ctrl_q), .vid_data(vid_data), .vid_inv(vid_inv),
    .vid_sg(vid_sg), .ext_char(ext_char)
  );

  chargen_ram #(.DW(DW), .AW(CNT_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(glyph_addr), .rdata(glyph_data)
  );

  a_r9_no_write_external: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !ext_char);

  a_r1_ram_write_from_bus: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (cpu_wr && cpu_addr == {BASE_ADDR[15:2], OFF_DATA}));
endmodule

// File: tb/chargen_ctrl_bench.sv
module chargen_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cpu_wr = 0;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [7:0]  cpu_rdata;
  logic [7:0]  vid_data = 8'h00;
  logic        vid_inv, vid_sg, ext_char;
  logic [10:0] glyph_addr = 11'd0;
  logic [7:0]  glyph_data;

  int checks = 0;
  int errors = 0;

  logic [7:0]  m_ctrl = 8'h00;
  logic [7:0]  m_data = 8'h00;
  logic [10:0] m_cnt = 11'd0;
  logic [7:0]  m_ram [2048];
  bit          m_valid [2048];
  logic [10:0] last_wr = 11'd0;
  bit          any_wr = 0;

  always #10 clk = ~clk;

  chargen_ctrl u_chargen_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .vid_data(vid_data),
    .vid_inv(vid_inv), .vid_sg(vid_sg), .ext_char(ext_char),
    .glyph_addr(glyph_addr), .glyph_data(glyph_data)
  );

  function automatic logic exp_inv(logic [7:0] c, logic [7:0] v);
    return c[1] ? v[6] : c[2];
  endfunction
  function automatic logic exp_sg(logic [7:0] c, logic [7:0] v);
    return c[3] ? v[7] : c[4];
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic bus_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(negedge clk);
    cpu_wr = 0;
    if (a == 16'hFF44) begin
      if (d[6] && !m_ctrl[6]) m_cnt = m_cnt + 1'b1;
      m_ctrl = d;
    end else if (a == 16'hFF46) begin
      m_data = d;
      if (m_ctrl[5] && !m_ctrl[0]) begin
        m_ram[m_cnt] = d; m_valid[m_cnt] = 1; last_wr = m_cnt; any_wr = 1;
      end
    end
  endtask

  task automatic read_check(string tag, logic [15:0] a, logic [7:0] exp);
    @(negedge clk);
    cpu_addr = a;
    #1 check(tag, cpu_rdata, exp);
  endtask

  task automatic glyph_check(string tag, logic [10:0] a, logic [7:0] exp);
    @(negedge clk);
    glyph_addr = a;
    @(negedge clk);
    check(tag, glyph_data, exp);
  endtask

  task automatic video_check(logic [7:0] v);
    @(negedge clk);
    vid_data = v;
    #1;
    check("R5 vid_inv", vid_inv, exp_inv(m_ctrl, v));
    check("R6 vid_sg", vid_sg, exp_sg(m_ctrl, v));
    check("R4 ext_char", ext_char, m_ctrl[0]);
  endtask

  task automatic advance_once();
    bus_write(16'hFF44, 8'h20);
    bus_write(16'hFF44, 8'h60);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R3 reset state
    read_check("R3 ctrl reset", 16'hFF44, 8'h00);
    read_check("R3 data reset", 16'hFF46, 8'h00);
    video_check(8'hFF);
    check("R3 outputs low", {ext_char, vid_inv, vid_sg}, 3'b000);

    // R8 write at counter 0 right after reset
    bus_write(16'hFF44, 8'h20);
    bus_write(16'hFF46, 8'h3C);
    glyph_check("R8 write at reset address", 11'd0, 8'h3C);

    // R1 decode neighbours
    bus_write(16'hFF40, 8'hFF);
    bus_write(16'hFF43, 8'h41);
    bus_write(16'hFF48, 8'h55);
    bus_write(16'hFE44, 8'h11);
    read_check("R1 ctrl unchanged", 16'hFF44, 8'h20);
    read_check("R1 outside reads 0", 16'hFF40, 8'h00);
    read_check("R1 outside reads 0 above", 16'hFF48, 8'h00);
    glyph_check("R1 no stray write", 11'd0, 8'h3C);

    // R2 unused offsets
    bus_write(16'hFF45, 8'h99);
    bus_write(16'hFF47, 8'h77);
    read_check("R2 off1 reads 0", 16'hFF45, 8'h00);
    read_check("R2 off3 reads 0", 16'hFF47, 8'h00);
    read_check("R2 ctrl kept", 16'hFF44, 8'h20);
    read_check("R2 data kept", 16'hFF46, 8'h3C);

    // R10 bit7 stored, no effect
    bus_write(16'hFF44, 8'h80);
    read_check("R10 bit7 readback", 16'hFF44, 8'h80);
    video_check(8'hC0);
    check("R10 outputs low", {ext_char, vid_inv, vid_sg}, 3'b000);

    // R5/R6 priority: auto beats manual
    bus_write(16'hFF44, 8'h1E);
    video_check(8'h00);
    check("R5 auto over manual", vid_inv, 1'b0);
    check("R6 auto over manual", vid_sg, 1'b0);
    video_check(8'hC0);

    // R7 level does not count; R9 suppression keeps known byte
    bus_write(16'hFF44, 8'h60);   // rise -> 1
    bus_write(16'hFF44, 8'h60);   // still high, no advance
    bus_write(16'hFF46, 8'hA1);   // at 1
    glyph_check("R7 no advance on level", 11'd1, 8'hA1);
    bus_write(16'hFF44, 8'h61);   // external source
    bus_write(16'hFF46, 8'hEE);
    glyph_check("R9 external suppresses", 11'd1, 8'hA1);
    bus_write(16'hFF44, 8'h40);   // write disabled
    bus_write(16'hFF46, 8'hDD);
    glyph_check("R9 disabled suppresses", 11'd1, 8'hA1);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 4);
      case (op)
        0: begin
          logic [7:0] c;
          c = 8'($urandom);
          if ($urandom_range(0, 3) != 0) c[0] = 1'b0;
          bus_write(16'hFF44, c);
        end
        1: bus_write(16'hFF46, 8'($urandom));
        2: if (any_wr) glyph_check("R8 random glyph", last_wr, m_ram[last_wr]);
        3: video_check(8'($urandom));
        default: begin
          read_check("R2 random ctrl", 16'hFF44, m_ctrl);
          read_check("R2 random data", 16'hFF46, m_data);
        end
      endcase
    end

    // R7 wrap
    bus_write(16'hFF44, 8'h20);
    while (m_cnt != 11'd2047) advance_once();
    bus_write(16'hFF44, 8'h20);
    bus_write(16'hFF46, 8'hA5);
    advance_once();
    check("R7 model wrapped", m_cnt, 11'd0);
    bus_write(16'hFF46, 8'h5A);
    glyph_check("R7 top address", 11'd2047, 8'hA5);
    glyph_check("R7 wrap to zero", 11'd0, 8'h5A);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule